// File: doc/BRIEF.md
# DMA Completion Event and Interrupt Tracker

This block sits beside the transfer engine of a multi-channel DMA controller and records what happens when transfer requests finish. Each finished request arrives as a one-cycle strobe. The strobe names the parameter set the request came from and says whether it was the last request of that set. The block keeps a small store of options words, one per parameter set. From the options word of the named set it takes a 6-bit completion code and four enables. These decide whether a bit is set in a 64-bit interrupt pending vector, in a 64-bit chained event vector, in both, or in neither.

The pending vector is masked with a 64-bit interrupt enable vector, and the result drives one level-sensitive CPU interrupt line. The chained event vector is brought out so that a channel scheduler can start follow-on transfers. The scheduler hands back a per-channel consume strobe to clear a bit once it has been taken. A small register port lets software read both vectors and the enables. Software can also clear pending and chained bits, force pending bits, and write the enables.

Whenever an options word is written, the block stamps it with the privilege level and the privilege ID of the writing master. Reserved fields are forced to zero.

Top module: `dce_top`

## Requirements
- R1: The completion code is options bits 17:12. Codes 0 to 31 select bit `code` of the low half (register address 0 for pending, address 6 for chained). Codes 32 to 63 select bit `code-32` of the high half (address 1 for pending, address 7 for chained). `chn_evt[code]` carries the same bit.
- R2: With options bit 21 set, a completion that is not the last of its set sets the pending bit selected by the code. A completion that is the last of its set does not set it through this enable.
- R3: With options bit 20 set, only a completion that is the last of its set sets the selected pending bit. A non-final completion does not set it through this enable.
- R4: Options bit 23 sets the selected chained bit on non-final completions. Options bit 22 sets it on final completions. Each enable has no effect on the other kind of completion.
- R5: `irq` is high exactly when some bit is set in both the pending vector and the enable vector. It stays high until software clears the bit or its enable.
- R6: Register port writes act as follows. Addresses 0 and 1 clear the pending bits written as 1. Addresses 2 and 3 set the pending bits written as 1. Addresses 4 and 5 load the low and high enable halves. Addresses 6 and 7 clear the chained bits written as 1. Reads of addresses 0 and 2 return the low pending half, 1 and 3 the high pending half, 4 and 5 the enables, and 6 and 7 the chained halves.
- R7: A write to an options word stores `mst_priv` in bit 31 and `mst_privid` in bits 27:24. The values written to those bits are ignored.
- R8: Options bits 30:28 and 19:18 always read as zero.
- R9: When a completion sets a bit in the same cycle that a software clear or a consume strobe clears it, the bit ends up set.
- R10: A completion whose options word has bits 23:20 all zero changes neither the pending vector nor the chained vector.
- R11: A chained bit stays set until it is cleared by a register write or by its bit of `chn_consume`.
- R12: After reset, every vector, every options word and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pset_wr | input | 1 | Write strobe for an options word |
| pset_sel | input | SEL_W | Parameter set being written |
| pset_wdata | input | 32 | Options word written |
| mst_priv | input | 1 | Privilege level of the writing master (1 = supervisor) |
| mst_privid | input | 4 | Privilege ID of the writing master |
| opt_rsel | input | SEL_W | Parameter set whose options word is read |
| opt_rdata | output | 32 | Stored options word of `opt_rsel` |
| cmpl_valid | input | 1 | One-cycle transfer request completion strobe |
| cmpl_sel | input | SEL_W | Parameter set of the completed request |
| cmpl_last | input | 1 | Completed request was the last of its set |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 3 | Register port address |
| reg_wdata | input | 32 | Register port write data |
| reg_rdata | output | 32 | Register port read data (combinational) |
| chn_consume | input | 64 | Per-channel clear strobe from the scheduler |
| chn_evt | output | 64 | Chained event vector |
| irq | output | 1 | CPU interrupt, level |

## Verification
The assertions assume that `cmpl_sel` and `pset_sel` name an existing set and that completion strobes last one cycle. They also assume that a completion reads the options word stored before that cycle, not one written in the same cycle. The bench writes each options word at least one cycle before the first completion that uses it. Its set indices stay below the set count. Some of its tests deliberately drive a completion together with a register write or a consume strobe in the same cycle, to exercise the collision rule.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int CODE_W  = 6;
  localparam int NBITS   = 1 << CODE_W;
  localparam int WORD    = 32;
  localparam int HALVES  = NBITS / WORD;

  localparam int B_PRIV  = 31;
  localparam int B_ICHN  = 23;
  localparam int B_FCHN  = 22;
  localparam int B_IINT  = 21;
  localparam int B_FINT  = 20;
  localparam int CODE_LO = 12;
  localparam int ID_LO   = 24;

  localparam logic [WORD-1:0] RSVD_MASK = 32'h700C_0000;

  function automatic logic [CODE_W-1:0] code_of(input logic [WORD-1:0] opt);
    return opt[CODE_LO +: CODE_W];
  endfunction

  function automatic logic [NBITS-1:0] bit_of(input logic [CODE_W-1:0] code);
    return {{(NBITS-1){1'b0}}, 1'b1} << code;
  endfunction

  function automatic logic [WORD-1:0] stamp(input logic [WORD-1:0] opt,
                                            input logic priv,
                                            input logic [3:0] id);
    logic [WORD-1:0] o;
    o = opt & ~RSVD_MASK;
    o[B_PRIV] = priv;
    o[ID_LO +: 4] = id;
    return o;
  endfunction
endpackage

// File: rtl/dce_optstore.sv
module dce_optstore #(
  parameter int NUM_SETS = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEL_W-1:0] wsel,
  input  logic [31:0]      wdata,
  input  logic             priv,
  input  logic [3:0]       privid,
  input  logic [SEL_W-1:0] rsel_a,
  output logic [31:0]      rdata_a,
  input  logic [SEL_W-1:0] rsel_b,
  output logic [31:0]      rdata_b
);
  import dce_pkg::*;

  logic [31:0] opt_q [NUM_SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SETS; i++) opt_q[i] <= '0;
    end else if (wr) begin
      opt_q[wsel] <= stamp(wdata, priv, privid);
    end
  end

  assign rdata_a = opt_q[rsel_a];
  assign rdata_b = opt_q[rsel_b];

  AST_PRIV_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (opt_q[$past(wsel)][B_PRIV] == $past(priv)) &&
           (opt_q[$past(wsel)][ID_LO +: 4] == $past(privid))); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_a & RSVD_MASK) == '0); // R8
endmodule

// File: rtl/dce_evtdec.sv
module dce_evtdec (
  input  logic                       valid,
  input  logic                       last,
  input  logic [31:0]                opt,
  output logic                       int_hit,
  output logic                       chn_hit,
  output logic [dce_pkg::NBITS-1:0]  pend_set,
  output logic [dce_pkg::NBITS-1:0]  chn_set
);
  import dce_pkg::*;

  logic [NBITS-1:0] sel_bit;

  assign sel_bit = bit_of(code_of(opt));
  assign int_hit = valid && (last ? opt[B_FINT] : opt[B_IINT]);
  assign chn_hit = valid && (last ? opt[B_FCHN] : opt[B_ICHN]);
  assign pend_set = int_hit ? sel_bit : '0;
  assign chn_set  = chn_hit ? sel_bit : '0;
endmodule

// File: rtl/dce_bitreg.sv
module dce_bitreg (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [dce_pkg::NBITS-1:0]  hw_set,
  input  logic [dce_pkg::NBITS-1:0]  sw_set,
  input  logic [dce_pkg::NBITS-1:0]  clr,
  output logic [dce_pkg::NBITS-1:0]  q
);
  import dce_pkg::*;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n) q[h*WORD +: WORD] <= '0;
      else q[h*WORD +: WORD] <= (q[h*WORD +: WORD] & ~clr[h*WORD +: WORD])
                               | sw_set[h*WORD +: WORD] | hw_set[h*WORD +: WORD];
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set))); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_set | sw_set | clr) == '0) |=> $stable(q)); // R11
endmodule

// File: rtl/dce_top.sv
module dce_top #(
  parameter int NUM_SETS = 4,
  localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pset_wr,
  input  logic [SEL_W-1:0] pset_sel,
  input  logic [31:0]      pset_wdata,
  input  logic             mst_priv,
  input  logic [3:0]       mst_privid,
  input  logic [SEL_W-1:0] opt_rsel,
  output logic [31:0]      opt_rdata,
  input  logic             cmpl_valid,
  input  logic [SEL_W-1:0] cmpl_sel,
  input  logic             cmpl_last,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [63:0]      chn_consume,
  output logic [63:0]      chn_evt,
  output logic             irq
);
  import dce_pkg::*;

  localparam logic [2:0] A_PCLR_LO = 3'd0, A_PCLR_HI = 3'd1,
                         A_PSET_LO = 3'd2, A_PSET_HI = 3'd3,
                         A_EN_LO   = 3'd4, A_EN_HI   = 3'd5,
                         A_CCLR_LO = 3'd6, A_CCLR_HI = 3'd7;

  logic [31:0]      cur_opt;
  logic [CODE_W-1:0] cur_code;
  logic             int_hit, chn_hit;
  logic [NBITS-1:0] pend_hw, chn_hw;
  logic [NBITS-1:0] pend_q, chn_q, en_q;
  logic [NBITS-1:0] pend_clr, pend_sw, chn_clr;
  logic [WORD-1:0]  wmask;

  dce_optstore #(.NUM_SETS(NUM_SETS), .SEL_W(SEL_W)) u_opt (
    .clk(clk), .rst_n(rst_n), .wr(pset_wr), .wsel(pset_sel), .wdata(pset_wdata),
    .priv(mst_priv), .privid(mst_privid),
    .rsel_a(opt_rsel), .rdata_a(opt_rdata),
    .rsel_b(cmpl_sel), .rdata_b(cur_opt)
  );

  assign cur_code = code_of(cur_opt);

  dce_evtdec u_dec (
    .valid(cmpl_valid), .last(cmpl_last), .opt(cur_opt),
    .int_hit(int_hit), .chn_hit(chn_hit),
    .pend_set(pend_hw), .chn_set(chn_hw)
  );

  assign wmask = reg_wr ? reg_wdata : '0;

  always_comb begin
    pend_clr = '0;
    pend_sw  = '0;
    chn_clr  = chn_consume;
    case (reg_addr)
      A_PCLR_LO: pend_clr[WORD-1:0]     = wmask;
      A_PCLR_HI: pend_clr[NBITS-1:WORD] = wmask;
      A_PSET_LO: pend_sw[WORD-1:0]      = wmask;
      A_PSET_HI: pend_sw[NBITS-1:WORD]  = wmask;
      A_CCLR_LO: chn_clr[WORD-1:0]      = chn_consume[WORD-1:0] | wmask;
      A_CCLR_HI: chn_clr[NBITS-1:WORD]  = chn_consume[NBITS-1:WORD] | wmask;
      default: ;
    endcase
  end

  dce_bitreg u_pend (
    .clk(clk), .rst_n(rst_n), .hw_set(pend_hw), .sw_set(pend_sw),
    .clr(pend_clr), .q(pend_q)
  );

  dce_bitreg u_chn (
    .clk(clk), .rst_n(rst_n), .hw_set(chn_hw), .sw_set('0),
    .clr(chn_clr), .q(chn_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (reg_wr && reg_addr == A_EN_LO) en_q[WORD-1:0]     <= reg_wdata;
    else if (reg_wr && reg_addr == A_EN_HI) en_q[NBITS-1:WORD] <= reg_wdata;
  end

  always_comb begin
    case (reg_addr)
      A_PCLR_LO, A_PSET_LO: reg_rdata = pend_q[WORD-1:0];
      A_PCLR_HI, A_PSET_HI: reg_rdata = pend_q[NBITS-1:WORD];
      A_EN_LO:              reg_rdata = en_q[WORD-1:0];
      A_EN_HI:              reg_rdata = en_q[NBITS-1:WORD];
      A_CCLR_LO:            reg_rdata = chn_q[WORD-1:0];
      default:              reg_rdata = chn_q[NBITS-1:WORD];
    endcase
  end

  assign chn_evt = chn_q;
  assign irq     = |(pend_q & en_q);

  AST_INTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !cmpl_last && cur_opt[B_IINT]) |=> pend_q[$past(cur_code)]); // R2
  AST_FINAL_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cmpl_last && cur_opt[B_FINT]) |=> pend_q[$past(cur_code)]); // R3
  AST_CHAIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && (cmpl_last ? cur_opt[B_FCHN] : cur_opt[B_ICHN])) |=> chn_q[$past(cur_code)]); // R4
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq); // R5
  AST_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cur_opt[23:20] == 4'd0 && !reg_wr && chn_consume == '0)
      |=> ($stable(pend_q) && $stable(chn_q))); // R10
  AST_RESET_IRQ: assert property (@(posedge clk)
    !rst_n |=> !irq); // R12
endmodule

// File: tb/dce_top_test.sv
module dce_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pset_wr = 1'b0;
  logic [1:0]  pset_sel = '0;
  logic [31:0] pset_wdata = '0;
  logic        mst_priv = 1'b0;
  logic [3:0]  mst_privid = '0;
  logic [1:0]  opt_rsel = '0;
  logic [31:0] opt_rdata;
  logic        cmpl_valid = 1'b0;
  logic [1:0]  cmpl_sel = '0;
  logic        cmpl_last = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] chn_consume = '0;
  logic [63:0] chn_evt;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dce_top #(.NUM_SETS(4)) uut (
    .clk(clk), .rst_n(rst_n), .pset_wr(pset_wr), .pset_sel(pset_sel),
    .pset_wdata(pset_wdata), .mst_priv(mst_priv), .mst_privid(mst_privid),
    .opt_rsel(opt_rsel), .opt_rdata(opt_rdata), .cmpl_valid(cmpl_valid),
    .cmpl_sel(cmpl_sel), .cmpl_last(cmpl_last), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chn_consume(chn_consume), .chn_evt(chn_evt), .irq(irq)
  );

  // options word built from the requirement fields
  function automatic logic [31:0] mk_opt(input logic ichn, input logic fchn,
                                         input logic iint, input logic fint,
                                         input int code);
    logic [31:0] o = '0;
    o[23] = ichn; o[22] = fchn; o[21] = iint; o[20] = fint;
    o[17:12] = code[5:0];
    return o;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    pset_wr = 1'b0; cmpl_valid = 1'b0; reg_wr = 1'b0; chn_consume = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr_opt(input int s, input logic [31:0] d, input logic p, input logic [3:0] id);
    pset_wr = 1'b1; pset_sel = s[1:0]; pset_wdata = d; mst_priv = p; mst_privid = id;
    step();
  endtask

  task automatic complete(input int s, input logic last);
    cmpl_valid = 1'b1; cmpl_sel = s[1:0]; cmpl_last = last;
    step();
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic clear_all();
    wreg(3'd0, '1); wreg(3'd1, '1); wreg(3'd6, '1); wreg(3'd7, '1);
    wreg(3'd4, '0); wreg(3'd5, '0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      check($sformatf("R12 reset reg %0d", a), {32'h0, d}, 64'h0);
    end
    check("R12 reset irq", {63'h0, irq}, 64'h0);
    opt_rsel = 2'd3; #1;
    check("R12 reset options word", {32'h0, opt_rdata}, 64'h0);
  endtask

  task automatic t_priv();
    wr_opt(3, 32'hFFFF_FFFF, 1'b0, 4'h5);
    opt_rsel = 2'd3; #1;
    check("R7 R8 stamp user id5", {32'h0, opt_rdata}, {32'h0, 32'h05F3_FFFF});
    wr_opt(3, 32'h0, 1'b1, 4'hA);
    #1;
    check("R7 stamp supervisor idA", {32'h0, opt_rdata}, {32'h0, 32'h8A00_0000});
  endtask

  task automatic t_inter();
    logic [31:0] d;
    clear_all();
    wr_opt(0, mk_opt(0, 0, 1, 0, 5), 1'b0, 4'h0);
    complete(0, 1'b0);
    rd(3'd0, d); check("R2 R1 intermediate sets bit 5", {32'h0, d}, 64'h20);
    wreg(3'd0, 32'h20);
    complete(0, 1'b1);
    rd(3'd0, d); check("R2 last ignored by intermediate enable", {32'h0, d}, 64'h0);
  endtask

  task automatic t_final();
    logic [31:0] d;
    clear_all();
    wr_opt(1, mk_opt(0, 0, 0, 1, 40), 1'b1, 4'h1);
    complete(1, 1'b0);
    rd(3'd1, d); check("R3 non-final ignored", {32'h0, d}, 64'h0);
    complete(1, 1'b1);
    rd(3'd1, d); check("R3 R1 final sets high bit 8", {32'h0, d}, 64'h100);
    rd(3'd0, d); check("R1 low half untouched", {32'h0, d}, 64'h0);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    clear_all();
    wr_opt(2, mk_opt(0, 1, 0, 0, 33), 1'b0, 4'h0);
    complete(2, 1'b0);
    check("R4 final chain ignores non-final", chn_evt, 64'h0);
    complete(2, 1'b1);
    check("R4 final chain sets 33", chn_evt, 64'h1 << 33);
    rd(3'd7, d); check("R1 chained high half", {32'h0, d}, 64'h2);
    rd(3'd1, d); check("R4 pending untouched by chaining", {32'h0, d}, 64'h0);
    wr_opt(2, mk_opt(1, 0, 0, 0, 3), 1'b0, 4'h0);
    complete(2, 1'b1);
    check("R4 intermediate chain ignores final", chn_evt, 64'h1 << 33);
    complete(2, 1'b0);
    check("R4 intermediate chain sets 3", chn_evt, (64'h1 << 33) | 64'h8);
    repeat (3) step();
    check("R11 chained bits held", chn_evt, (64'h1 << 33) | 64'h8);
    chn_consume = 64'h8; step();
    check("R11 consume clears bit 3", chn_evt, 64'h1 << 33);
    wreg(3'd7, 32'h2);
    check("R6 W1C clears chained 33", chn_evt, 64'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    clear_all();
    wr_opt(0, mk_opt(0, 0, 1, 0, 5), 1'b0, 4'h0);
    complete(0, 1'b0);
    check("R5 masked pending gives no irq", {63'h0, irq}, 64'h0);
    wreg(3'd4, 32'h20);
    check("R5 enabled pending raises irq", {63'h0, irq}, 64'h1);
    rd(3'd4, d); check("R6 enable low readback", {32'h0, d}, 64'h20);
    repeat (4) step();
    check("R5 irq level held", {63'h0, irq}, 64'h1);
    wreg(3'd0, 32'h20);
    check("R5 R6 clear drops irq", {63'h0, irq}, 64'h0);
    wreg(3'd3, 32'h8000_0000);
    rd(3'd1, d); check("R6 software set high bit 31", {32'h0, d}, 64'h8000_0000);
    wreg(3'd5, 32'h8000_0000);
    check("R5 high half irq", {63'h0, irq}, 64'h1);
    wreg(3'd1, 32'h8000_0000);
    check("R6 high clear drops irq", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_none();
    logic [31:0] d;
    clear_all();
    wreg(3'd2, 32'h1);
    wr_opt(3, mk_opt(0, 0, 0, 0, 9), 1'b0, 4'h0);
    complete(3, 1'b0);
    complete(3, 1'b1);
    rd(3'd0, d); check("R10 pending unchanged", {32'h0, d}, 64'h1);
    check("R10 chained unchanged", chn_evt, 64'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    clear_all();
    wr_opt(0, mk_opt(1, 0, 1, 0, 5), 1'b0, 4'h0);
    wreg(3'd2, 32'h20);
    cmpl_valid = 1'b1; cmpl_sel = 2'd0; cmpl_last = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h20;
    chn_consume = 64'h20;
    step();
    rd(3'd0, d); check("R9 set beats W1C on pending", {32'h0, d}, 64'h20);
    check("R9 set beats consume on chained", chn_evt, 64'h20);
    cmpl_valid = 1'b1; cmpl_sel = 2'd0; cmpl_last = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h20;
    step();
    check("R9 set beats W1C on chained", chn_evt, 64'h20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_priv();
    t_inter();
    t_final();
    t_chain();
    t_irq();
    t_none();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule